// File: doc/BRIEF.md
# Oversampled Serial Receiver with Start Qualification

This block receives asynchronous serial characters from a single data line. An oversample tick runs at sixteen times the bit rate (a parameter), and the receive line is read only on tick cycles. When a falling edge is seen on an idle line, the receiver checks the line again at three points inside the start bit. A 2-of-3 vote decides whether the start bit is real, and any disagreement among the three samples is reported as noise. Each data bit and the stop bit are then decided by a majority of three samples taken around the bit centre. Characters carry eight data bits, or nine when the mode input is high. Bits arrive least significant first.

A zero stop bit is a framing error. If every bit of the character, stop slot included, was zero, the character is a break: the receiver reports it with zero data and then waits until the line has been seen high before it hunts again. A framing error that is not a break is handled as if a stop bit had been present. The receiver places an artificial start edge exactly one bit time after the stop bit began, so a character that follows back to back stays aligned. A character never starts earlier than that point.

Each finished character raises a single-cycle ready pulse. The data and the three status flags change only with that pulse and hold until the next one.

Top module: `uart_rx_qual`

## Requirements
- R1: A synchronous reset clears the data and all flags and drops the ready pulse. After reset, a start edge is recognised only once the line has been sampled high at least once.
- R2: With a falling edge on a tick defined as sample 0, the line is verified at samples 3, 5 and 7. The start bit is accepted when at least two of those three samples are 0.
- R3: When fewer than two verification samples are 0, the edge is discarded, no character is produced and the receiver hunts again.
- R4: The noise flag of a character is set when its three start verification samples are not all 0, even though the start bit was accepted.
- R5: Each data bit and the stop bit take the majority of samples 8, 9 and 10 of their bit time (16 samples per bit, the start edge being sample 0 of bit 0). Data bits arrive LSB first into rx_data[0] upward. A disagreement among the three samples of any such bit sets the noise flag.
- R6: wide_mode is sampled when the start bit is accepted. Low selects 8 data bits with rx_data[8] = 0; high selects 9 data bits. A change during the character has no effect on that character.
- R7: rx_ready is high for exactly one clock per character, on the cycle after the tick that decides the stop bit. rx_data, frame_err, noise_err and break_det change only together with rx_ready.
- R8: A stop bit that votes 0 sets frame_err with the received data. If the character is not a break, the tick one full bit time after the stop bit began is taken as a new start edge whatever the line level, and it is verified as in R2 and R3.
- R9: A character whose data bits and stop bit all vote 0 is a break (10 zero bit times in 8-bit mode, 11 in 9-bit mode). It raises rx_ready with frame_err = 1, break_det = 1 and rx_data = 0, and no artificial start edge follows.
- R10: After a break, a low line is never taken as a start edge until the line has been sampled high.
- R11: Only clock cycles with os_tick high sample the line or advance the receiver. A low level present only on other cycles has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| os_tick | input | 1 | Oversample strobe, one clock wide, OSR per bit |
| rx_in | input | 1 | Serial receive line (already synchronous to clk) |
| wide_mode | input | 1 | 1 = nine data bits, 0 = eight |
| rx_data | output | BASE_BITS+1 | Last received character, LSB first on the line |
| rx_ready | output | 1 | One-clock pulse per finished character |
| frame_err | output | 1 | Stop bit of the last character was 0 |
| noise_err | output | 1 | A sample disagreement occurred in the last character |
| break_det | output | 1 | Last character was a break |

## Verification
The bench puts one high sample at verification point 5 and expects an accepted start with noise. A receiver that used a single sample, or that required all three samples, would drop or misread that character. A short low pulse that is high again by sample 3 must produce nothing; a receiver without verification would frame garbage from the idle line. Back-to-back characters after a zero stop bit must both decode, which catches a receiver that hunts for a fresh edge instead of placing the artificial one. A line held low for many bit times after a break must yield exactly one character, which catches a receiver that re-arms without seeing the line high. A mode change in the middle of a character, and non-tick glitches on the line, must leave the decoded data unchanged.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   typedef enum logic [1:0] {
      ST_HUNT   = 2'd0,
      ST_VERIFY = 2'd1,
      ST_RECV   = 2'd2,
      ST_ART    = 2'd3
   } rxq_state_t;
endpackage

// File: rtl/rxq_vote3.sv
module rxq_vote3 (
   input  logic a_i,
   input  logic b_i,
   input  logic c_i,
   output logic maj_o,
   output logic split_o
);
   assign maj_o   = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
   assign split_o = (a_i ^ b_i) | (a_i ^ c_i);
endmodule

// File: rtl/rxq_shift.sv
module rxq_shift #(
   parameter int W = 9
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 clr_i,
   input  logic                 wr_i,
   input  logic [$clog2(W)-1:0] idx_i,
   input  logic                 bit_i,
   output logic [W-1:0]         q_o
);
   localparam int IW = $clog2(W);

   for (genvar i = 0; i < W; i++) begin : g_cell
      always_ff @(posedge clk) begin
         if (rst || clr_i) begin
            q_o[i] <= 1'b0;
         end else if (wr_i && idx_i == IW'(i)) begin
            q_o[i] <= bit_i;
         end
      end
   end
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
   import rxq_pkg::*;
#(
   parameter int OSR       = 16,
   parameter int BASE_BITS = 8
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic                            tick_i,
   input  logic                            rx_i,
   input  logic                            wide_i,
   input  logic [BASE_BITS:0]              sr_q_i,
   output logic                            sr_clr_o,
   output logic                            sr_wr_o,
   output logic [$clog2(BASE_BITS+1)-1:0]  sr_idx_o,
   output logic                            sr_bit_o,
   output logic [BASE_BITS:0]              data_o,
   output logic                            ready_o,
   output logic                            fe_o,
   output logic                            nf_o,
   output logic                            brk_o
);
   localparam int CW = $clog2(OSR);
   localparam int NW = CW + 1;
   localparam int BW = $clog2(BASE_BITS + 3);
   localparam int IW = $clog2(BASE_BITS + 1);
   localparam int DW = BASE_BITS + 1;
   localparam logic [NW-1:0] V1   = NW'(OSR / 2 - 5);
   localparam logic [NW-1:0] V2   = NW'(OSR / 2 - 3);
   localparam logic [NW-1:0] V3   = NW'(OSR / 2 - 1);
   localparam logic [NW-1:0] D1   = NW'(OSR / 2);
   localparam logic [NW-1:0] D2   = NW'(OSR / 2 + 1);
   localparam logic [NW-1:0] D3   = NW'(OSR / 2 + 2);
   localparam logic [NW-1:0] WRAP = NW'(OSR);
   localparam logic [BW-1:0] NB_N = BW'(BASE_BITS);
   localparam logic [BW-1:0] NB_W = BW'(BASE_BITS + 1);

   rxq_state_t      state;
   logic [CW-1:0]   cnt;
   logic [BW-1:0]   bidx;
   logic            s1, s2;
   logic            wide_q;
   logic            noise_acc;
   logic            any_one;
   logic            armed;

   logic [NW-1:0]   ncnt;
   logic [CW-1:0]   cnt_nx;
   logic            wrap;
   logic [BW-1:0]   nbits;
   logic [BW-1:0]   stop_idx;
   logic            maj, split;
   logic            is_vote, is_data, is_stop;
   logic            hunt_edge, art_edge;

   rxq_vote3 u_vote (
      .a_i     (s1),
      .b_i     (s2),
      .c_i     (rx_i),
      .maj_o   (maj),
      .split_o (split)
   );

   always_comb begin
      ncnt      = {1'b0, cnt} + NW'(1);
      wrap      = (ncnt == WRAP);
      cnt_nx    = wrap ? '0 : ncnt[CW-1:0];
      nbits     = wide_q ? NB_W : NB_N;
      stop_idx  = nbits + BW'(1);
      is_vote   = (state == ST_RECV) && (ncnt == D3) && (bidx != '0);
      is_data   = is_vote && (bidx <= nbits);
      is_stop   = is_vote && (bidx == stop_idx);
      hunt_edge = (state == ST_HUNT) && armed && !rx_i;
      art_edge  = (state == ST_ART) && wrap;
   end

   assign sr_clr_o = tick_i && (hunt_edge || art_edge);
   assign sr_wr_o  = tick_i && is_data;
   assign sr_idx_o = IW'(bidx - BW'(1));
   assign sr_bit_o = maj;

   always_ff @(posedge clk) begin
      if (rst) begin
         state     <= ST_HUNT;
         cnt       <= '0;
         bidx      <= '0;
         s1        <= 1'b0;
         s2        <= 1'b0;
         wide_q    <= 1'b0;
         noise_acc <= 1'b0;
         any_one   <= 1'b0;
         armed     <= 1'b0;
         data_o    <= '0;
         ready_o   <= 1'b0;
         fe_o      <= 1'b0;
         nf_o      <= 1'b0;
         brk_o     <= 1'b0;
      end else begin
         ready_o <= 1'b0;
         if (tick_i) begin
            unique case (state)
               ST_HUNT: begin
                  if (rx_i) begin
                     armed <= 1'b1;
                  end else if (armed) begin
                     state <= ST_VERIFY;
                     cnt   <= '0;
                  end
               end
               ST_VERIFY: begin
                  cnt <= cnt_nx;
                  if (ncnt == V1) s1 <= rx_i;
                  if (ncnt == V2) s2 <= rx_i;
                  if (ncnt == V3) begin
                     if (!maj) begin
                        state     <= ST_RECV;
                        bidx      <= '0;
                        wide_q    <= wide_i;
                        noise_acc <= split;
                        any_one   <= 1'b0;
                     end else begin
                        state <= ST_HUNT;
                        armed <= 1'b1;
                     end
                  end
               end
               ST_RECV: begin
                  cnt <= cnt_nx;
                  if (wrap) bidx <= bidx + BW'(1);
                  if (ncnt == D1) s1 <= rx_i;
                  if (ncnt == D2) s2 <= rx_i;
                  if (is_data) begin
                     noise_acc <= noise_acc | split;
                     any_one   <= any_one | maj;
                  end
                  if (is_stop) begin
                     ready_o <= 1'b1;
                     fe_o    <= ~maj;
                     nf_o    <= noise_acc | split;
                     brk_o   <= ~maj & ~any_one;
                     data_o  <= (~maj & ~any_one) ? '0 : sr_q_i;
                     if (maj) begin
                        state <= ST_HUNT;
                        armed <= 1'b1;
                     end else if (!any_one) begin
                        state <= ST_HUNT;
                        armed <= 1'b0;
                     end else begin
                        state <= ST_ART;
                     end
                  end
               end
               ST_ART: begin
                  cnt <= cnt_nx;
                  if (wrap) begin
                     state <= ST_VERIFY;
                     cnt   <= '0;
                  end
               end
               default: state <= ST_HUNT;
            endcase
         end
      end
   end

   logic unused_dw;
   assign unused_dw = ^DW;
endmodule

// File: rtl/uart_rx_qual.sv
module uart_rx_qual #(
   parameter int OSR       = 16,
   parameter int BASE_BITS = 8
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 os_tick,
   input  logic                 rx_in,
   input  logic                 wide_mode,
   output logic [BASE_BITS:0]   rx_data,
   output logic                 rx_ready,
   output logic                 frame_err,
   output logic                 noise_err,
   output logic                 break_det
);
   localparam int DW = BASE_BITS + 1;
   localparam int IW = $clog2(DW);

   if (OSR < 12 || (OSR % 2) != 0) begin : g_bad_osr
      $error("uart_rx_qual: OSR must be even and at least 12");
   end
   if (BASE_BITS < 5 || BASE_BITS > 16) begin : g_bad_bits
      $error("uart_rx_qual: BASE_BITS must lie in 5..16");
   end

   logic          sr_clr, sr_wr, sr_bit;
   logic [IW-1:0] sr_idx;
   logic [DW-1:0] sr_q;

   rxq_shift #(.W(DW)) u_shift (
      .clk   (clk),
      .rst   (rst),
      .clr_i (sr_clr),
      .wr_i  (sr_wr),
      .idx_i (sr_idx),
      .bit_i (sr_bit),
      .q_o   (sr_q)
   );

   rxq_ctrl #(.OSR(OSR), .BASE_BITS(BASE_BITS)) u_ctrl (
      .clk      (clk),
      .rst      (rst),
      .tick_i   (os_tick),
      .rx_i     (rx_in),
      .wide_i   (wide_mode),
      .sr_q_i   (sr_q),
      .sr_clr_o (sr_clr),
      .sr_wr_o  (sr_wr),
      .sr_idx_o (sr_idx),
      .sr_bit_o (sr_bit),
      .data_o   (rx_data),
      .ready_o  (rx_ready),
      .fe_o     (frame_err),
      .nf_o     (noise_err),
      .brk_o    (break_det)
   );
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
   parameter int DW = 9
) (
   input logic          clk,
   input logic          rst,
   input logic          os_tick,
   input logic [DW-1:0] rx_data,
   input logic          rx_ready,
   input logic          frame_err,
   input logic          noise_err,
   input logic          break_det
);
   // R7: ready lasts one clock
   assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (rst)
      rx_ready |=> !rx_ready);

   // R7: outputs only move with the ready pulse
   assert_flags_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !rx_ready |-> ($stable(rx_data) && $stable(frame_err)
                     && $stable(noise_err) && $stable(break_det)));

   // R11: a character completes only on a tick
   assert_ready_on_tick_R11: assert property (@(posedge clk) disable iff (rst)
      rx_ready |-> $past(os_tick));

   // R9: a break reports a framing error with zero data
   assert_break_zero_R9: assert property (@(posedge clk) disable iff (rst)
      (rx_ready && break_det) |-> (frame_err && rx_data == '0));

   // R9: break never stands without a framing error
   assert_break_fe_R9: assert property (@(posedge clk) disable iff (rst)
      break_det |-> frame_err);
endmodule

bind uart_rx_qual rxq_checker #(.DW(BASE_BITS + 1)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .os_tick   (os_tick),
   .rx_data   (rx_data),
   .rx_ready  (rx_ready),
   .frame_err (frame_err),
   .noise_err (noise_err),
   .break_det (break_det)
);

// File: tb/uart_rx_qual_tb_top.sv
module uart_rx_qual_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int TICK_DIV   = 4;
   localparam int SPB        = 16;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       os_tick = 1'b0;
   logic       rx_in = 1'b1;
   logic       wide_mode = 1'b0;
   logic [8:0] rx_data;
   logic       rx_ready, frame_err, noise_err, break_det;

   int errors = 0;
   int checks = 0;
   int rdy_cnt = 0;
   int tcnt = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(negedge clk) begin
      tcnt    <= (tcnt == TICK_DIV - 1) ? 0 : tcnt + 1;
      os_tick <= (tcnt == TICK_DIV - 1);
   end

   always @(posedge clk) if (rx_ready) rdy_cnt <= rdy_cnt + 1;

   uart_rx_qual dut_i (
      .clk       (clk),
      .rst       (rst),
      .os_tick   (os_tick),
      .rx_in     (rx_in),
      .wide_mode (wide_mode),
      .rx_data   (rx_data),
      .rx_ready  (rx_ready),
      .frame_err (frame_err),
      .noise_err (noise_err),
      .break_det (break_det)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic hold(input logic lvl, input int n);
      @(negedge clk);
      rx_in = lvl;
      for (int i = 0; i < n; i++) begin
         do @(posedge clk); while (!os_tick);
      end
   endtask

   task automatic send(input logic [8:0] d, input int nb, input logic stop_lvl);
      hold(1'b0, SPB);
      for (int i = 0; i < nb; i++) hold(d[i], SPB);
      hold(stop_lvl, SPB);
   endtask

   task automatic expect_char(input string req, input int n0, input int d,
                              input int fe, input int nf, input int brk);
      chk({req, " ready count"}, rdy_cnt - n0, 1);
      chk({req, " data"}, int'(rx_data), d);
      chk({req, " frame_err"}, int'(frame_err), fe);
      chk({req, " noise_err"}, int'(noise_err), nf);
      chk({req, " break_det"}, int'(break_det), brk);
   endtask

   task automatic t_reset_R1();
      chk("R1 reset data", int'(rx_data), 0);
      chk("R1 reset ready", int'(rx_ready), 0);
      chk("R1 reset flags", int'({frame_err, noise_err, break_det}), 0);
      begin
         int n0 = rdy_cnt;
         hold(1'b0, 40);
         chk("R1 no start before high", rdy_cnt - n0, 0);
      end
      hold(1'b1, 20);
   endtask

   task automatic t_clean_R2();
      int n0 = rdy_cnt;
      send(9'h0A5, 8, 1'b1);
      expect_char("R2 clean A5", n0, 'hA5, 0, 0, 0);
      hold(1'b1, 5);
      n0 = rdy_cnt;
      send(9'h03C, 8, 1'b1);
      expect_char("R5 clean 3C", n0, 'h3C, 0, 0, 0);
      hold(1'b1, 8);
   endtask

   task automatic t_verify_noise_R4();
      logic [7:0] d = 8'hC3;
      int n0 = rdy_cnt;
      hold(1'b0, 5); hold(1'b1, 1); hold(1'b0, 10);
      for (int i = 0; i < 8; i++) hold(d[i], SPB);
      hold(1'b1, SPB);
      expect_char("R4 start noise", n0, 'hC3, 0, 1, 0);
      hold(1'b1, 8);
   endtask

   task automatic t_reject_R3();
      int n0 = rdy_cnt;
      hold(1'b0, 3); hold(1'b1, 40);
      chk("R3 rejected edge no ready", rdy_cnt - n0, 0);
      n0 = rdy_cnt;
      send(9'h081, 8, 1'b1);
      expect_char("R3 frame after reject", n0, 'h81, 0, 0, 0);
      hold(1'b1, 8);
   endtask

   task automatic t_data_noise_R5();
      logic [7:0] d = 8'h96;
      int n0 = rdy_cnt;
      hold(1'b0, SPB);
      for (int i = 0; i < 8; i++) begin
         if (i == 2) begin
            hold(d[i], 9); hold(~d[i], 1); hold(d[i], 6);
         end else begin
            hold(d[i], SPB);
         end
      end
      hold(1'b1, SPB);
      expect_char("R5 data sample noise", n0, 'h96, 0, 1, 0);
      hold(1'b1, 8);
   endtask

   task automatic t_nine_R6();
      int n0 = rdy_cnt;
      wide_mode = 1'b1;
      send(9'h1A5, 9, 1'b1);
      expect_char("R6 nine bit", n0, 'h1A5, 0, 0, 0);
      hold(1'b1, 8);
      wide_mode = 1'b0;
      n0 = rdy_cnt;
      hold(1'b0, SPB);
      wide_mode = 1'b1;
      for (int i = 0; i < 8; i++) hold(1'((8'hF5 >> i) & 1), SPB);
      hold(1'b1, SPB);
      hold(1'b1, SPB);
      expect_char("R6 mode latched at start", n0, 'hF5, 0, 0, 0);
      wide_mode = 1'b0;
      hold(1'b1, 8);
   endtask

   task automatic t_fe_back_to_back_R8();
      int n0 = rdy_cnt;
      send(9'h0A5, 8, 1'b0);
      expect_char("R8 framing error data", n0, 'hA5, 1, 0, 0);
      n0 = rdy_cnt;
      send(9'h03C, 8, 1'b1);
      expect_char("R8 artificial start aligned", n0, 'h3C, 0, 0, 0);
      hold(1'b1, 8);
   endtask

   task automatic t_fe_idle_R8();
      int n0 = rdy_cnt;
      send(9'h05A, 8, 1'b0);
      expect_char("R8 framing error then idle", n0, 'h5A, 1, 0, 0);
      n0 = rdy_cnt;
      hold(1'b1, 40);
      chk("R8 high line no extra char", rdy_cnt - n0, 0);
      n0 = rdy_cnt;
      send(9'h011, 8, 1'b1);
      expect_char("R8 recover after idle", n0, 'h11, 0, 0, 0);
      hold(1'b1, 8);
   endtask

   task automatic t_break_R9(input logic wide, input int nzero, input string tag);
      int n0 = rdy_cnt;
      wide_mode = wide;
      hold(1'b0, nzero * SPB);
      expect_char({"R9 break ", tag}, n0, 0, 1, 0, 1);
      n0 = rdy_cnt;
      hold(1'b0, 20 * SPB);
      chk({"R10 low after break ", tag}, rdy_cnt - n0, 0);
      hold(1'b1, 20);
      n0 = rdy_cnt;
      send(9'h077, wide ? 9 : 8, 1'b1);
      expect_char({"R10 char after break ", tag}, n0, 'h77, 0, 0, 0);
      wide_mode = 1'b0;
      hold(1'b1, 8);
   endtask

   task automatic t_glitch_R11();
      int n0 = rdy_cnt;
      for (int k = 0; k < 6; k++) begin
         do @(posedge clk); while (!os_tick);
         @(negedge clk); rx_in = 1'b0;
         @(negedge clk);
         @(negedge clk); rx_in = 1'b1;
      end
      hold(1'b1, 20);
      chk("R11 off-tick glitch ignored", rdy_cnt - n0, 0);
      n0 = rdy_cnt;
      send(9'h0E1, 8, 1'b1);
      expect_char("R11 frame after glitches", n0, 'hE1, 0, 0, 0);
      hold(1'b1, 8);
   endtask

   task automatic t_mid_reset_R1();
      hold(1'b0, 10 * SPB);
      chk("R1 break before reset", int'(break_det), 1);
      @(negedge clk); rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk("R1 reset clears flags", int'({frame_err, noise_err, break_det}), 0);
      chk("R1 reset clears data", int'(rx_data), 0);
      hold(1'b1, 20);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset_R1();
      t_clean_R2();
      t_verify_noise_R4();
      t_reject_R3();
      t_data_noise_R5();
      t_nine_R6();
      t_fe_back_to_back_R8();
      t_fe_idle_R8();
      t_break_R9(1'b0, 10, "8-bit");
      t_break_R9(1'b1, 11, "9-bit");
      t_glitch_R11();
      t_mid_reset_R1();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule